// File: doc/BRIEF.md
# Scan Sequencer Watchdog Monitor

This block watches a scanning port sequencer for two kinds of fault. The first is a stall: the sequencer emits an end-of-scan pulse once per scan, and a retriggerable activity timer counts clock-enable strobes since the last such pulse. If the count reaches a set limit, the timer expires and sets a sticky loss-of-scan flag. The second is an address mismatch, reported as a pulse by an external comparator.

Both faults feed one OR term. That term is sampled into a sequencer error flag on each clock-enable strobe. A mismatch also raises a write-mode request on the following clock. The comparator and the memory it guards are outside the block.

The activity timer stays disarmed after reset until the first end-of-scan pulse. A sequencer that has not started yet is therefore never reported as stalled.

Top module: `scan_watchdog`

## Requirements
- R1: After reset, `loss_o`, `seq_err_o` and `wr_req_o` are all low, and the timer is disarmed.
- R2: While no end-of-scan pulse has been seen since reset, any number of strobes leaves `loss_o` and `seq_err_o` low.
- R3: After an end-of-scan pulse, the timer expires on the clock edge that accepts the TIMEOUT_TICKS-th strobe with no pulse in between. Pulses spaced fewer strobes apart never cause expiry.
- R4: Timer expiry sets `loss_o` on the next clock edge.
- R5: `loss_o` is sticky. A new end-of-scan pulse does not clear it. A high `clr_loss_i` clears it at the next edge unless the timer is expired at that time, in which case setting wins.
- R6: On each clock edge with `tick_i` high, `seq_err_o` takes the value (timer expired OR `nocmp_i`). On edges with `tick_i` low it holds its value.
- R7: `wr_req_o` equals `nocmp_i` delayed by one clock, independent of `tick_i`.
- R8: An end-of-scan pulse in the same cycle as a strobe restarts the timer. The strobe is not counted.
- R9: Once expired, the timer stays expired until the next end-of-scan pulse, which returns it to the running state with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eos_pulse_i | input | 1 | End-of-scan pulse from the sequencer |
| nocmp_i | input | 1 | Address no-compare pulse from the comparator |
| tick_i | input | 1 | System clock-enable strobe |
| clr_loss_i | input | 1 | Clears the sticky loss flag |
| loss_o | output | 1 | Loss-of-end-of-scan flag, sticky |
| seq_err_o | output | 1 | Sequencer diagnostic error flag |
| wr_req_o | output | 1 | Write-mode request |

## Verification
The bench builds the block with TIMEOUT_TICKS = 3. With that limit, a sweep of scan gaps from zero to seven strobes crosses the expiry boundary on both sides and covers the extra strobe that `seq_err_o` needs. In each sweep step, the expected loss flag is (gap >= 3) and the expected error flag is (gap >= 4). The small limit also keeps the cases short: a same-cycle restart, a clear that collides with expiry, and mismatch pulses with and without a strobe.

// File: rtl/scan_wd_pkg.sv
package scan_wd_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE    = 2'd0,
    TMR_RUN     = 2'd1,
    TMR_EXPIRED = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/scan_wd_timer.sv
module scan_wd_timer
  import scan_wd_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (restart_i) begin
      // restart has priority over a same-cycle strobe
      state_d = TMR_RUN;
      cnt_d   = '0;
    end else if (state_q == TMR_RUN && tick_i) begin
      if (cnt_q == LAST) begin
        state_d = TMR_EXPIRED;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign expired_o = (state_q == TMR_EXPIRED);
endmodule

// File: rtl/scan_wd_loss_latch.sv
module scan_wd_loss_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/scan_wd_err_reg.sv
module scan_wd_err_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fault_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (tick_i) q_o <= fault_i;
  end
endmodule

// File: rtl/scan_watchdog.sv
module scan_watchdog #(
  parameter int unsigned TIMEOUT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eos_pulse_i,
  input  logic nocmp_i,
  input  logic tick_i,
  input  logic clr_loss_i,
  output logic loss_o,
  output logic seq_err_o,
  output logic wr_req_o
);
  logic expired;
  logic fault;

  scan_wd_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(eos_pulse_i),
    .tick_i   (tick_i),
    .expired_o(expired)
  );

  scan_wd_loss_latch u_loss (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (expired),
    .clr_i (clr_loss_i),
    .q_o   (loss_o)
  );

  // shared fault term: stall or address mismatch
  assign fault = expired | nocmp_i;

  scan_wd_err_reg u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .fault_i(fault),
    .q_o    (seq_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_req_o <= 1'b0;
    else         wr_req_o <= nocmp_i;
  end
endmodule

// File: rtl/scan_watchdog_chk.sv
module scan_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic eos_pulse_i,
  input logic nocmp_i,
  input logic tick_i,
  input logic clr_loss_i,
  input logic expired,
  input logic loss_o,
  input logic seq_err_o,
  input logic wr_req_o
);
  a_r7_wr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nocmp_i |=> wr_req_o);
  a_r7_wr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nocmp_i |=> !wr_req_o);
  a_r6_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(seq_err_o));
  a_r6_err_on_nocmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && nocmp_i) |=> seq_err_o);
  a_r6_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !nocmp_i && !expired) |=> !seq_err_o);
  a_r4_loss_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired |=> loss_o);
  a_r5_loss_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_o && !clr_loss_i) |=> loss_o);
  a_r5_loss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_loss_i && !expired) |=> !loss_o);
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_pulse_i |=> !expired);
  a_r9_expired_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired && !eos_pulse_i) |=> expired);
endmodule

bind scan_watchdog scan_watchdog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eos_pulse_i(eos_pulse_i),
  .nocmp_i    (nocmp_i),
  .tick_i     (tick_i),
  .clr_loss_i (clr_loss_i),
  .expired    (expired),
  .loss_o     (loss_o),
  .seq_err_o  (seq_err_o),
  .wr_req_o   (wr_req_o)
);

// File: tb/scan_watchdog_test.sv
module scan_watchdog_test;
  localparam int T = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic eos = 1'b0, nc = 1'b0, tk = 1'b0, clr = 1'b0;
  logic loss, err, wr;
  int   errors = 0, checks = 0;

  always #10 clk = ~clk; // 50 MHz

  scan_watchdog #(.TIMEOUT_TICKS(T)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .eos_pulse_i(eos), .nocmp_i(nc),
    .tick_i(tk), .clr_loss_i(clr), .loss_o(loss), .seq_err_o(err), .wr_req_o(wr)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // one clock with the given inputs; returns at the following negedge
  task automatic cyc(input logic e, input logic n, input logic t, input logic c);
    eos = e; nc = n; tk = t; clr = c;
    @(posedge clk);
    @(negedge clk);
    eos = 0; nc = 0; tk = 0; clr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 loss after reset", loss, 1'b0);
    chk("R1 err after reset", err, 1'b0);
    chk("R1 wr after reset", wr, 1'b0);

    // R2: unarmed timer never expires
    ticks(4 * T + 2);
    chk("R2 loss unarmed", loss, 1'b0);
    chk("R2 err unarmed", err, 1'b0);

    // R3/R4/R6: gap sweep
    for (int n = 0; n <= 2 * T + 1; n++) begin
      do_reset();
      cyc(1, 0, 0, 0);
      ticks(n);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk($sformatf("R3 R4 loss gap=%0d", n), loss, logic'(n >= T));
      chk($sformatf("R6 err gap=%0d", n), err, logic'(n >= T + 1));
    end

    // R3: periodic pulses just inside the limit
    do_reset();
    for (int p = 0; p < 6; p++) begin
      cyc(1, 0, 0, 0);
      ticks(T - 1);
    end
    cyc(0, 0, 0, 0);
    chk("R3 periodic no loss", loss, 1'b0);

    // R8: pulse with strobe in same cycle restarts, strobe not counted
    do_reset();
    cyc(1, 0, 0, 0);
    ticks(T - 1);
    cyc(1, 0, 1, 0);
    ticks(T - 1);
    cyc(0, 0, 0, 0);
    chk("R8 same-cycle restart", loss, 1'b0);
    ticks(1);
    cyc(0, 0, 0, 0);
    chk("R8 expiry after restart", loss, 1'b1);

    // R5/R9: sticky loss, clear, set wins
    do_reset();
    cyc(1, 0, 0, 0);
    ticks(T + 2);
    chk("R9 err stays while expired", err, 1'b1);
    cyc(0, 0, 0, 1);
    chk("R5 clear loses to expiry", loss, 1'b1);
    cyc(1, 0, 0, 0);
    chk("R5 pulse does not clear", loss, 1'b1);
    cyc(0, 0, 1, 0);
    chk("R9 pulse ends expiry", err, 1'b0);
    cyc(0, 0, 0, 1);
    chk("R5 clear works", loss, 1'b0);

    // R6/R7: mismatch path
    do_reset();
    cyc(0, 1, 0, 0);
    chk("R7 wr after nocmp", wr, 1'b1);
    chk("R6 no strobe no err", err, 1'b0);
    cyc(0, 0, 0, 0);
    chk("R7 wr drops", wr, 1'b0);
    cyc(0, 1, 1, 0);
    chk("R6 err on strobe", err, 1'b1);
    chk("R7 wr with strobe", wr, 1'b1);
    cyc(0, 0, 0, 0);
    chk("R6 err holds", err, 1'b1);
    cyc(0, 0, 1, 0);
    chk("R6 err clears", err, 1'b0);
    chk("R6 no loss from nocmp", loss, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule